// File: doc/BRIEF.md
# Boot Configuration Loader with Checksum Fallback

This block runs once after every reset and fills a small bank of configuration registers without any command from a host. It has three places to get that configuration from and tries them strictly in turn: an external serial EEPROM behind a word-wide read port, then a 64-byte on-chip fuse array behind a byte-wide read port, and finally a constant built into the design. Each external source must pass its own 8-bit complement checksum (the fuse array must also not be blank) before anything from it reaches the outputs.

Both read ports use a request/valid handshake with any latency, so the block works behind a slow serial engine or a fuse sense circuit alike. Bytes from a candidate source go into a staging copy while the checksum is accumulated; only after the verdict is known is the visible bank overwritten, in a single cycle, together with a source code and a one-cycle completion pulse. After that the block stays quiet until the next reset.

Top module: `cfg_boot_loader`

## Requirements
- R1: With reset released and no other stimulus, the block reads EEPROM word addresses 03h, 04h and 05h in that order, one request at a time.
- R2: A read request stays high with a constant address until the cycle in which valid is also high; that cycle accepts the data, whatever the latency.
- R3: The EEPROM passes when the low byte of word 05h equals 0xFF minus the 8-bit wrap-around sum of the low and high bytes of words 03h and 04h; the bank then holds word 03h low, word 03h high, word 04h low, word 04h high as bytes 0 to 3 (byte n at bits 8n+7:8n) and the source code is 0.
- R4: An EEPROM response with the error flag set ends the EEPROM attempt at once: no further EEPROM address is requested and the source counts as failed.
- R5: After an EEPROM failure, fuse bytes are read from address 00h upward.
- R6: A fuse byte 00h of 0xFF marks the array blank: no further fuse byte is read and the defaults are applied.
- R7: The fuse passes when byte 00h is not 0xFF and byte 19h equals 0xFF minus the 8-bit sum of bytes 00h to 18h (all 25 of them are read, then byte 19h); the bank then holds fuse bytes 01h to 04h as bytes 0 to 3 and the source code is 1.
- R8: When neither source passes, the bank holds the `DEF_CFG` parameter and the source code is 2; code 3 never appears.
- R9: From reset until completion the bank holds `DEF_CFG` and the source code is 2; no byte from a source that is still being checked or has failed ever reaches the outputs.
- R10: The done output is high for exactly one cycle; the bank and source code change in that same cycle, two clock edges after the edge that accepted the final read.
- R11: After completion no read is requested and the outputs keep their values until the next reset.
- R12: The two read requests are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loading starts when it is released |
| ee_req | output | 1 | EEPROM read request |
| ee_addr | output | EE_AW (8) | EEPROM word address |
| ee_valid | input | 1 | EEPROM response valid |
| ee_err | input | 1 | EEPROM absent or unreadable, qualified by ee_valid |
| ee_data | input | 16 | EEPROM word, low byte in bits 7:0 |
| fu_req | output | 1 | Fuse read request |
| fu_addr | output | FU_AW (6) | Fuse byte address |
| fu_valid | input | 1 | Fuse response valid |
| fu_data | input | 8 | Fuse byte |
| cfg_data | output | 32 | Configuration bank, byte n at bits 8n+7:8n |
| cfg_src | output | 2 | 0 EEPROM, 1 fuse, 2 defaults |
| cfg_done | output | 1 | One-cycle completion pulse |

## Verification
A request follows one cycle after the edge that accepted the previous response, and the bank, source code and done pulse are due exactly two edges after the edge that accepted the last read of the chosen path. The bench plans that path from the memory contents it loads, answers each request with a varying delay, and when it presents the final response arms a two-edge countdown in its reference model. Outputs are sampled on falling edges and compared against the model every cycle, so an early, late or repeated update shows up as a mismatch in a specific cycle.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    // Layout of the EEPROM words examined by the loader.
    localparam int EE_WORD_FIRST = 3;
    localparam int EE_WORD_CSUM  = 5;

    // Layout of the fuse bytes examined by the loader.
    localparam int FU_BYTE_CSUM  = 25;
    localparam int FU_CFG_FIRST  = 1;
    localparam logic [7:0] BLANK_MARK = 8'hFF;

    // Size of the visible configuration bank.
    localparam int CFG_BYTES = 4;
    localparam int CFG_W     = CFG_BYTES * 8;

    typedef enum logic [2:0] {
        ST_START,
        ST_EE_RD,
        ST_EE_CHK,
        ST_FU_RD,
        ST_FU_CHK,
        ST_COMMIT,
        ST_DONE
    } ld_state_e;

    typedef enum logic [1:0] {
        SRC_EE  = 2'd0,
        SRC_FU  = 2'd1,
        SRC_DEF = 2'd2
    } cfg_src_e;

    typedef struct packed {
        logic [CFG_BYTES-1:0] mask;
        logic [CFG_W-1:0]     data;
    } stage_wr_t;

    function automatic logic csum_ok(input logic [7:0] sum, input logic [7:0] stored);
        return stored == 8'(8'hFF - sum);
    endfunction

endpackage

// File: rtl/cfgld_csum.sv
module cfgld_csum #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               add_en,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] lane_data,
    output logic [7:0]         sum
);
    logic [7:0] sum_q;
    logic [7:0] acc;

    always_comb begin
        acc = sum_q;
        for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) begin
                acc = acc + lane_data[l*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= acc;
        end
    end

    assign sum = sum_q;
endmodule

// File: rtl/cfgld_bank.sv
module cfgld_bank
    import cfgld_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_CFG = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_wr_t        wr,
    input  logic             commit,
    input  logic             use_def,
    output logic [CFG_W-1:0] cfg
);
    logic [7:0] stage_q [CFG_BYTES];
    logic [7:0] cfg_q   [CFG_BYTES];

    for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= '0;
            end else if (wr.mask[i]) begin
                stage_q[i] <= wr.data[i*8 +: 8];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= DEF_CFG[i*8 +: 8];
            end else if (commit) begin
                cfg_q[i] <= use_def ? DEF_CFG[i*8 +: 8] : stage_q[i];
            end
        end

        assign cfg[i*8 +: 8] = cfg_q[i];
    end
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
#(
    parameter int EE_AW = 8,
    parameter int FU_AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    output logic             ee_req,
    output logic [EE_AW-1:0] ee_addr,
    input  logic             ee_valid,
    input  logic             ee_err,
    input  logic [15:0]      ee_data,
    output logic             fu_req,
    output logic [FU_AW-1:0] fu_addr,
    input  logic             fu_valid,
    input  logic [7:0]       fu_data,
    input  logic [7:0]       sum,
    output logic             csum_clr,
    output logic             csum_add,
    output logic [1:0]       lane_en,
    output logic [15:0]      lane_data,
    output stage_wr_t        stage_wr,
    output logic             commit,
    output logic             use_def,
    output logic [1:0]       src_o,
    output logic             done_o
);
    localparam int IW = FU_AW;
    localparam logic [IW-1:0] EE_LAST_IDX = IW'(EE_WORD_CSUM - EE_WORD_FIRST);
    localparam logic [IW-1:0] FU_LAST_IDX = IW'(FU_BYTE_CSUM);
    localparam logic [IW-1:0] FU_CFG_LO   = IW'(FU_CFG_FIRST);
    localparam logic [IW-1:0] FU_CFG_HI   = IW'(FU_CFG_FIRST + CFG_BYTES - 1);

    ld_state_e       state_q;
    logic [IW-1:0]   idx_q;
    logic            fail_q;
    logic [7:0]      stored_q;
    cfg_src_e        pick_q;
    cfg_src_e        src_q;
    logic            done_q;

    logic            ee_take;
    logic            fu_take;
    logic            fu_blank;
    logic [IW-1:0]   fu_rel;

    assign ee_req   = (state_q == ST_EE_RD);
    assign fu_req   = (state_q == ST_FU_RD);
    assign ee_addr  = EE_AW'(EE_WORD_FIRST) + EE_AW'(idx_q);
    assign fu_addr  = idx_q;
    assign ee_take  = ee_req && ee_valid;
    assign fu_take  = fu_req && fu_valid;
    assign fu_blank = (idx_q == '0) && (fu_data == BLANK_MARK);
    assign fu_rel   = idx_q - FU_CFG_LO;

    // Datapath steering: checksum lanes and staging writes.
    always_comb begin
        csum_clr  = (state_q == ST_EE_CHK);
        csum_add  = 1'b0;
        lane_en   = '0;
        lane_data = ee_data;
        stage_wr  = '0;
        commit    = (state_q == ST_COMMIT);
        use_def   = (pick_q == SRC_DEF);
        unique case (state_q)
            ST_EE_RD: begin
                if (ee_take && !ee_err && idx_q < EE_LAST_IDX) begin
                    csum_add      = 1'b1;
                    lane_en       = 2'b11;
                    stage_wr.mask = CFG_BYTES'(2'b11) << {idx_q, 1'b0};
                    stage_wr.data = CFG_W'(ee_data) << {idx_q, 4'b0000};
                end
            end
            ST_FU_RD: begin
                lane_data = {8'h00, fu_data};
                if (fu_take && !fu_blank && idx_q < FU_LAST_IDX) begin
                    csum_add = 1'b1;
                    lane_en  = 2'b01;
                    if (idx_q >= FU_CFG_LO && idx_q <= FU_CFG_HI) begin
                        stage_wr.mask = CFG_BYTES'(1) << fu_rel;
                        stage_wr.data = CFG_W'(fu_data) << {fu_rel, 3'b000};
                    end
                end
            end
            default: ;
        endcase
    end

    // Sequencing of sources and verdicts.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_START;
            idx_q    <= '0;
            fail_q   <= 1'b0;
            stored_q <= '0;
            pick_q   <= SRC_DEF;
            src_q    <= SRC_DEF;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_START: begin
                    idx_q   <= '0;
                    fail_q  <= 1'b0;
                    state_q <= ST_EE_RD;
                end
                ST_EE_RD: begin
                    if (ee_take) begin
                        if (ee_err) begin
                            fail_q  <= 1'b1;
                            state_q <= ST_EE_CHK;
                        end else if (idx_q == EE_LAST_IDX) begin
                            stored_q <= ee_data[7:0];
                            state_q  <= ST_EE_CHK;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_EE_CHK: begin
                    if (!fail_q && csum_ok(sum, stored_q)) begin
                        pick_q  <= SRC_EE;
                        state_q <= ST_COMMIT;
                    end else begin
                        idx_q   <= '0;
                        fail_q  <= 1'b0;
                        state_q <= ST_FU_RD;
                    end
                end
                ST_FU_RD: begin
                    if (fu_take) begin
                        if (fu_blank) begin
                            fail_q  <= 1'b1;
                            state_q <= ST_FU_CHK;
                        end else if (idx_q == FU_LAST_IDX) begin
                            stored_q <= fu_data;
                            state_q  <= ST_FU_CHK;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_FU_CHK: begin
                    pick_q  <= (!fail_q && csum_ok(sum, stored_q)) ? SRC_FU : SRC_DEF;
                    state_q <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    src_q   <= pick_q;
                    done_q  <= 1'b1;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    assign src_o  = src_q;
    assign done_o = done_q;
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cfgld_pkg::*;
#(
    parameter int               EE_AW    = 8,
    parameter int               FU_DEPTH = 64,
    parameter logic [CFG_W-1:0] DEF_CFG  = 32'h5A3C_9612
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic                        ee_req,
    output logic [EE_AW-1:0]            ee_addr,
    input  logic                        ee_valid,
    input  logic                        ee_err,
    input  logic [15:0]                 ee_data,
    output logic                        fu_req,
    output logic [$clog2(FU_DEPTH)-1:0] fu_addr,
    input  logic                        fu_valid,
    input  logic [7:0]                  fu_data,
    output logic [CFG_W-1:0]            cfg_data,
    output logic [1:0]                  cfg_src,
    output logic                        cfg_done
);
    localparam int FU_AW = $clog2(FU_DEPTH);

    logic [7:0]  sum;
    logic        csum_clr;
    logic        csum_add;
    logic [1:0]  lane_en;
    logic [15:0] lane_data;
    stage_wr_t   stage_wr;
    logic        commit;
    logic        use_def;

    cfgld_ctrl #(
        .EE_AW (EE_AW),
        .FU_AW (FU_AW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ee_req    (ee_req),
        .ee_addr   (ee_addr),
        .ee_valid  (ee_valid),
        .ee_err    (ee_err),
        .ee_data   (ee_data),
        .fu_req    (fu_req),
        .fu_addr   (fu_addr),
        .fu_valid  (fu_valid),
        .fu_data   (fu_data),
        .sum       (sum),
        .csum_clr  (csum_clr),
        .csum_add  (csum_add),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .stage_wr  (stage_wr),
        .commit    (commit),
        .use_def   (use_def),
        .src_o     (cfg_src),
        .done_o    (cfg_done)
    );

    cfgld_csum #(
        .LANES (2)
    ) u_csum (
        .clk       (clk),
        .rst       (rst),
        .clr       (csum_clr),
        .add_en    (csum_add),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .sum       (sum)
    );

    cfgld_bank #(
        .DEF_CFG (DEF_CFG)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (stage_wr),
        .commit  (commit),
        .use_def (use_def),
        .cfg     (cfg_data)
    );
endmodule

// File: rtl/cfg_boot_loader_chk.sv
module cfg_boot_loader_chk #(
    parameter int EE_AW = 8,
    parameter int FU_AW = 6,
    parameter int CW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ee_req,
    input logic [EE_AW-1:0] ee_addr,
    input logic             ee_valid,
    input logic             ee_err,
    input logic             fu_req,
    input logic [FU_AW-1:0] fu_addr,
    input logic             fu_valid,
    input logic [7:0]       fu_data,
    input logic [CW-1:0]    cfg_data,
    input logic [1:0]       cfg_src,
    input logic             cfg_done
);
    logic done_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_seen_q <= 1'b0;
        end else if (cfg_done) begin
            done_seen_q <= 1'b1;
        end
    end

    // R12
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ee_req, fu_req}));

    // R2
    ee_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ee_req && !ee_valid) |=> (ee_req && $stable(ee_addr)));

    // R2
    fu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fu_req && !fu_valid) |=> (fu_req && $stable(fu_addr)));

    // R4
    ee_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (ee_req && ee_valid && ee_err) |=> !ee_req);

    // R6
    fu_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (fu_req && fu_valid && fu_addr == '0 && fu_data == 8'hFF) |=> !fu_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> !cfg_done);

    // R9
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> ($stable(cfg_data) && $stable(cfg_src)));

    // R11
    idle_after_chk: assert property (@(posedge clk) disable iff (rst)
        done_seen_q |-> (!ee_req && !fu_req));

    // R8
    src_code_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_src != 2'd3);
endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(
    .EE_AW (EE_AW),
    .FU_AW (FU_AW),
    .CW    (cfgld_pkg::CFG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ee_req   (ee_req),
    .ee_addr  (ee_addr),
    .ee_valid (ee_valid),
    .ee_err   (ee_err),
    .fu_req   (fu_req),
    .fu_addr  (fu_addr),
    .fu_valid (fu_valid),
    .fu_data  (fu_data),
    .cfg_data (cfg_data),
    .cfg_src  (cfg_src),
    .cfg_done (cfg_done)
);

// File: tb/cfg_boot_loader_bench.sv
module cfg_boot_loader_bench;
    localparam logic [31:0] DEF = 32'h5A3C_9612;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ee_req;
    logic [7:0]  ee_addr;
    logic        ee_valid = 1'b0;
    logic        ee_err = 1'b0;
    logic [15:0] ee_data = '0;
    logic        fu_req;
    logic [5:0]  fu_addr;
    logic        fu_valid = 1'b0;
    logic [7:0]  fu_data = '0;
    logic [31:0] cfg_data;
    logic [1:0]  cfg_src;
    logic        cfg_done;

    always #4 clk = ~clk;

    cfg_boot_loader u_cfg_boot_loader (
        .clk      (clk),
        .rst      (rst),
        .ee_req   (ee_req),
        .ee_addr  (ee_addr),
        .ee_valid (ee_valid),
        .ee_err   (ee_err),
        .ee_data  (ee_data),
        .fu_req   (fu_req),
        .fu_addr  (fu_addr),
        .fu_valid (fu_valid),
        .fu_data  (fu_data),
        .cfg_data (cfg_data),
        .cfg_src  (cfg_src),
        .cfg_done (cfg_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] ee_mem [256];
    logic [7:0]  fu_mem [64];
    int          ee_err_at;
    int          q_ee[$];
    int          q_fu[$];
    logic [31:0] m_cfg;
    logic [31:0] fin_cfg;
    logic [1:0]  m_src;
    logic [1:0]  fin_src;
    int          rem;
    bit          fin_seen;
    bit          active = 1'b0;
    int          lat_seed = 0;
    int          ee_wait = 0;
    int          fu_wait = 0;
    string       cur_tag = "R9";

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic int next_lat();
        lat_seed = lat_seed + 1;
        return (lat_seed * 5 + lat_seed / 3) % 4;
    endfunction

    // Expected read sequence and final result, from the requirements.
    task automatic plan();
        logic [7:0] s;
        bit ok;
        q_ee.delete();
        q_fu.delete();
        ok = 1'b1;
        s  = 8'h00;
        for (int w = 3; w <= 5; w++) begin
            q_ee.push_back(w);
            if (w == ee_err_at) begin
                ok = 1'b0;
                break;
            end
            if (w < 5) s = s + ee_mem[w][7:0] + ee_mem[w][15:8];
        end
        if (ok) ok = (ee_mem[5][7:0] == 8'(8'hFF - s));
        if (ok) begin
            fin_cfg = {ee_mem[4], ee_mem[3]};
            fin_src = 2'd0;
        end else begin
            q_fu.push_back(0);
            if (fu_mem[0] == 8'hFF) begin
                fin_cfg = DEF;
                fin_src = 2'd2;
            end else begin
                s = 8'h00;
                for (int a = 1; a <= 25; a++) q_fu.push_back(a);
                for (int a = 0; a <= 24; a++) s = s + fu_mem[a];
                if (fu_mem[25] == 8'(8'hFF - s)) begin
                    fin_cfg = {fu_mem[4], fu_mem[3], fu_mem[2], fu_mem[1]};
                    fin_src = 2'd1;
                end else begin
                    fin_cfg = DEF;
                    fin_src = 2'd2;
                end
            end
        end
    endtask

    task automatic set_ee(input logic [15:0] w3, input logic [15:0] w4, input bit good);
        logic [7:0] s;
        for (int i = 0; i < 256; i++) ee_mem[i] = 16'h0000;
        ee_mem[3] = w3;
        ee_mem[4] = w4;
        s = w3[7:0] + w3[15:8] + w4[7:0] + w4[15:8];
        ee_mem[5] = {8'hC3, good ? 8'(8'hFF - s) : 8'(8'hFF - s) ^ 8'h40};
    endtask

    task automatic set_fu(input logic [7:0] b0, input int seed, input bit good);
        logic [7:0] s;
        fu_mem[0] = b0;
        for (int a = 1; a < 64; a++) fu_mem[a] = 8'(a * seed + 3);
        s = 8'h00;
        for (int a = 0; a <= 24; a++) s = s + fu_mem[a];
        fu_mem[25] = good ? 8'(8'hFF - s) : 8'(8'hFF - s + 8'h01);
    endtask

    // Reference model and responders, evaluated on falling edges.
    always @(negedge clk) begin
        logic exp_done;
        if (active && !rst) begin
            exp_done = 1'b0;
            if (rem == 0) begin
                exp_done = 1'b1;
                m_cfg    = fin_cfg;
                m_src    = fin_src;
                rem      = -1;
                fin_seen = 1'b1;
            end else if (rem > 0) begin
                rem = rem - 1;
            end
            chk("R10", cfg_done, exp_done, "done pulse");
            chk(fin_seen ? cur_tag : "R9", cfg_data, m_cfg, "cfg_data");
            chk(fin_seen ? cur_tag : "R9", cfg_src, m_src, "cfg_src");
            chk("R12", ee_req && fu_req, 1'b0, "both requests");
            if (fin_seen) chk("R11", ee_req || fu_req, 1'b0, "request after done");

            if (ee_valid) begin
                ee_valid = 1'b0;
                ee_err   = 1'b0;
            end else if (ee_req) begin
                if (ee_wait > 0) begin
                    ee_wait = ee_wait - 1;
                end else if (q_ee.size() == 0) begin
                    chk(cur_tag, 1'b1, 1'b0, "unplanned eeprom request");
                end else begin
                    chk("R1,R2", ee_addr, q_ee[0], "eeprom address");
                    void'(q_ee.pop_front());
                    ee_data  = ee_mem[ee_addr];
                    ee_err   = (int'(ee_addr) == ee_err_at);
                    ee_valid = 1'b1;
                    ee_wait  = next_lat();
                    if (q_ee.size() == 0 && q_fu.size() == 0) rem = 2;
                end
            end

            if (fu_valid) begin
                fu_valid = 1'b0;
            end else if (fu_req) begin
                if (fu_wait > 0) begin
                    fu_wait = fu_wait - 1;
                end else if (q_fu.size() == 0) begin
                    chk(cur_tag, 1'b1, 1'b0, "unplanned fuse request");
                end else begin
                    chk("R5", fu_addr, q_fu[0], "fuse address");
                    void'(q_fu.pop_front());
                    fu_data  = fu_mem[fu_addr];
                    fu_valid = 1'b1;
                    fu_wait  = next_lat();
                    if (q_fu.size() == 0) rem = 2;
                end
            end
        end
    end

    task automatic run_case(input string tag);
        active   = 1'b0;
        rst      = 1'b1;
        ee_valid = 1'b0;
        fu_valid = 1'b0;
        ee_err   = 1'b0;
        ee_wait  = 0;
        fu_wait  = 0;
        cur_tag  = tag;
        plan();
        m_cfg    = DEF;
        m_src    = 2'd2;
        rem      = -1;
        fin_seen = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", cfg_data, DEF, "reset cfg_data");
        chk("R9", cfg_src, 2'd2, "reset cfg_src");
        chk("R10", cfg_done, 1'b0, "reset done");
        chk("R1", ee_req || fu_req, 1'b0, "request during reset");
        active = 1'b1;
        rst    = 1'b0;
        for (int i = 0; i < 600 && !fin_seen; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(tag, fin_seen, 1'b1, "completion reached");
        chk(tag, q_ee.size() + q_fu.size(), 0, "planned reads left");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R3: good EEPROM, fuse would also pass but must not be read
        ee_err_at = -1;
        set_ee(16'hA1B2, 16'h0C3D, 1'b1);
        set_fu(8'h12, 5, 1'b1);
        run_case("R3");

        // R3: sum that wraps past 8 bits several times
        set_ee(16'hFFFE, 16'h8081, 1'b1);
        run_case("R3");

        // R7: EEPROM checksum wrong, fuse good
        set_ee(16'h1357, 16'h9BDF, 1'b0);
        set_fu(8'h12, 7, 1'b1);
        run_case("R7");

        // R4: EEPROM error on word 04h after word 03h was staged, fuse good with byte 00h zero
        ee_err_at = 4;
        set_ee(16'h4455, 16'h6677, 1'b1);
        set_fu(8'h00, 11, 1'b1);
        run_case("R4");

        // R6: EEPROM absent at first word, fuse blank
        ee_err_at = 3;
        set_fu(8'hFF, 13, 1'b1);
        run_case("R6");

        // R8: EEPROM checksum wrong, fuse checksum wrong, defaults after a full fuse scan
        ee_err_at = -1;
        set_ee(16'hBEEF, 16'h0110, 1'b0);
        set_fu(8'h21, 3, 1'b0);
        run_case("R8");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule